// File: doc/BRIEF.md
# Bus Width and Address Adapter

This bridge sits between a 32-bit bus master and a single slave whose data path is 8, 16, 32 or 64 bits wide. The master presents byte addresses and four active-low byte enables. The slave takes word addresses, where one word is as wide as the slave's data path. The bridge turns each master access into the slave accesses it needs. When the slave is narrower than 32 bits, one master access becomes up to four slave accesses. Each of these is issued only for a slave word that has at least one enabled byte. The master is held in wait until the last of them is done.

A byte keeps its byte address across the bridge. Slave word `w`, lane `j` holds byte `w*SB + j`, where `SB` is the slave width in bytes. Read data from narrow accesses is collected and returned on the master lanes the bytes belong to. A 64-bit slave sees the master word in one half of its lanes. Master address bit 2 selects the half, and the other half is disabled. The slave width is fixed by the parameter `SLV_W`. The sequencing needs no extra cycle: the master completes in the same cycle as the last slave handshake.

Top module: `wadp_width_bridge`

## Requirements
- R1: Byte `i` of a master word at byte address `A` (bits 1:0 zero) reaches slave word `(A+i)/SB` on lane `(A+i) mod SB`, where `SB = SLV_W/8`. A byte written through the bridge reads back from the same master address and lane.
- R2: For an 8- or 16-bit slave, the bridge issues exactly one slave access for each slave-width group of master lanes that has at least one enable at 0. The accesses go in ascending address order. A group whose enables are all 1 gets no access.
- R3: A master access with all four enables at 1 completes in a single cycle and produces no slave access, at every slave width.
- R4: The master wait signal stays at 1 until the last slave access of the master access is accepted, and this includes every cycle the slave itself waits. A master access therefore lasts the sum of (slave wait cycles + 1) over its slave accesses.
- R5: Read data on every enabled master lane equals the byte stored at that lane's byte address, and this includes bytes gathered from earlier slave accesses.
- R6: A write changes only the bytes whose master enable is 0. All other bytes keep their stored values.
- R7: With a 64-bit slave, a write drives the master enables onto lanes 7..4 when master address bit 2 is 1 and onto lanes 3..0 when it is 0. All enables of the other half are held at 1.
- R8: With a 32-bit slave, each master access that has an enabled byte becomes exactly one slave access.
- R9: While the master requests nothing, including right after reset, the bridge drives no slave read or write and holds the master wait at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_addr | input | M_ADDR_W | Master byte address (bits 1:0 zero) |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_be_n | input | 4 | Master byte enables, active low |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data to the master |
| m_wait | output | 1 | Holds the master while the access is in progress |
| s_addr | output | M_ADDR_W-log2(SLV_W/8) | Slave word address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_be_n | output | SLV_W/8 | Slave byte enables, active low |
| s_wdata | output | SLV_W | Write data to the slave |
| s_rdata | input | SLV_W | Read data from the slave, valid when s_wait is 0 |
| s_wait | input | 1 | Slave wait request |

## Verification
The properties assume that a master keeps its address, enables, data and strobe steady for as long as wait is 1, and that it never raises read and write together. The bench's master task obeys both rules: it changes its inputs only on falling edges, and it drops each bridge's strobe only after that bridge's final accepted cycle. The bench's slave model returns data in the cycle its wait falls. Its number of wait cycles rotates through 0, 1 and 2 from one access to the next, so the hold-on-wait properties are exercised with both stalled and unstalled beats.

// File: rtl/wadp_pkg.sv
package wadp_pkg;
   localparam int MST_W     = 32;
   localparam int MST_BYTES = MST_W / 8;

   function automatic int beats_for(input int slv_w);
      return (slv_w < MST_W) ? (MST_W / slv_w) : 1;
   endfunction
endpackage

// File: rtl/wadp_beat_seq.sv
module wadp_beat_seq #(
   parameter  int NBEAT = 2,
   localparam int IDX_W = (NBEAT > 1) ? $clog2(NBEAT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [NBEAT-1:0] act,
   input  logic             s_wait,
   output logic [IDX_W-1:0] cur,
   output logic             issue,
   output logic             fire,
   output logic             mdone
);
   logic [NBEAT-1:0] done_q;
   logic [NBEAT-1:0] pending;
   logic [NBEAT-1:0] cur_oh;
   logic             last;

   assign pending = act & ~done_q;

   // lowest pending beat wins
   always_comb begin
      cur = '0;
      for (int k = NBEAT - 1; k >= 0; k--) begin
         if (pending[k]) cur = IDX_W'(k);
      end
   end

   assign cur_oh = NBEAT'(1) << cur;
   assign last   = ((pending & ~cur_oh) == '0);
   assign issue  = req & (|pending);
   assign fire   = issue & ~s_wait;
   assign mdone  = req & (~(|pending) | (fire & last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              done_q <= '0;
      else if (mdone || !req)  done_q <= '0;
      else if (fire)           done_q <= done_q | cur_oh;
   end

   AST_PICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> act[cur]);                                    // R2
   AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && s_wait) |=> (issue && $stable(cur)));         // R4
   AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      mdone |=> (done_q == '0));                              // R4
endmodule

// File: rtl/wadp_rd_gather.sv
module wadp_rd_gather #(
   parameter  int SLV_W = 8,
   parameter  int NBEAT = 4,
   localparam int IDX_W = (NBEAT > 1) ? $clog2(NBEAT) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fire,
   input  logic [IDX_W-1:0]       cur,
   input  logic [SLV_W-1:0]       s_rdata,
   output logic [NBEAT*SLV_W-1:0] m_rdata
);
   for (genvar k = 0; k < NBEAT; k++) begin : g_beat
      logic             hit;
      logic [SLV_W-1:0] held;

      assign hit = fire && (cur == IDX_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   held <= '0;
         else if (hit) held <= s_rdata;
      end

      // the final beat is forwarded in the cycle it is accepted
      assign m_rdata[k*SLV_W +: SLV_W] = hit ? s_rdata : held;
   end
endmodule

// File: rtl/wadp_width_bridge.sv
module wadp_width_bridge #(
   parameter int SLV_W    = 16,
   parameter int M_ADDR_W = 16
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [M_ADDR_W-1:0]                   m_addr,
   input  logic                                  m_read,
   input  logic                                  m_write,
   input  logic [3:0]                            m_be_n,
   input  logic [31:0]                           m_wdata,
   output logic [31:0]                           m_rdata,
   output logic                                  m_wait,
   output logic [M_ADDR_W-$clog2(SLV_W/8)-1:0]   s_addr,
   output logic                                  s_read,
   output logic                                  s_write,
   output logic [SLV_W/8-1:0]                    s_be_n,
   output logic [SLV_W-1:0]                      s_wdata,
   input  logic [SLV_W-1:0]                      s_rdata,
   input  logic                                  s_wait
);
   import wadp_pkg::*;

   localparam int SB    = SLV_W / 8;
   localparam int NBEAT = beats_for(SLV_W);
   localparam int IDX_W = (NBEAT > 1) ? $clog2(NBEAT) : 1;

   if (!(SLV_W == 8 || SLV_W == 16 || SLV_W == 32 || SLV_W == 64)) begin : g_bad_w
      $error("wadp_width_bridge: SLV_W must be 8, 16, 32 or 64");
   end
   if (M_ADDR_W < 4) begin : g_bad_a
      $error("wadp_width_bridge: M_ADDR_W must be at least 4");
   end

   logic             req;
   logic [NBEAT-1:0] act;
   logic [IDX_W-1:0] cur;
   logic             issue;
   logic             fire;
   logic             mdone;

   assign req = m_read | m_write;

   wadp_beat_seq #(.NBEAT(NBEAT)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .act   (act),
      .s_wait(s_wait),
      .cur   (cur),
      .issue (issue),
      .fire  (fire),
      .mdone (mdone)
   );

   assign m_wait  = req & ~mdone;
   assign s_read  = m_read  & issue;
   assign s_write = m_write & issue;

   if (SLV_W < MST_W) begin : g_narrow
      logic [SB-1:0]    be_beat [NBEAT];
      logic [SLV_W-1:0] wd_beat [NBEAT];
      logic             unused_lo;

      for (genvar k = 0; k < NBEAT; k++) begin : g_lane
         assign be_beat[k] = m_be_n[k*SB +: SB];
         assign wd_beat[k] = m_wdata[k*SLV_W +: SLV_W];
         assign act[k]     = ~&be_beat[k];
      end

      assign s_addr    = {m_addr[M_ADDR_W-1:2], cur};
      assign s_be_n    = be_beat[cur];
      assign s_wdata   = wd_beat[cur];
      assign unused_lo = ^m_addr[1:0];

      wadp_rd_gather #(.SLV_W(SLV_W), .NBEAT(NBEAT)) u_gather (
         .clk    (clk),
         .rst_n  (rst_n),
         .fire   (fire),
         .cur    (cur),
         .s_rdata(s_rdata),
         .m_rdata(m_rdata)
      );

      AST_LANE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (s_read || s_write) |-> !(&s_be_n));                 // R2
   end else if (SLV_W == MST_W) begin : g_equal
      logic unused_lo;

      assign act[0]    = ~&m_be_n;
      assign s_addr    = m_addr[M_ADDR_W-1:2];
      assign s_be_n    = m_be_n;
      assign s_wdata   = m_wdata;
      assign m_rdata   = s_rdata;
      assign unused_lo = ^{m_addr[1:0], cur};

      AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         (s_read || s_write) && !s_wait |-> !m_wait);         // R8
   end else begin : g_wide
      logic upper;
      logic unused_lo;

      assign upper     = m_addr[2];
      assign act[0]    = ~&m_be_n;
      assign s_addr    = m_addr[M_ADDR_W-1:3];
      assign s_be_n    = upper ? {m_be_n, 4'hF} : {4'hF, m_be_n};
      assign s_wdata   = {m_wdata, m_wdata};
      assign m_rdata   = upper ? s_rdata[63:32] : s_rdata[31:0];
      assign unused_lo = ^{m_addr[1:0], cur};

      AST_HALF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         s_write |-> ((&s_be_n[7:4]) || (&s_be_n[3:0])));      // R7
   end

   AST_WAIT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_read || s_write) && s_wait) |-> m_wait);             // R4
   AST_NO_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (!s_read && !s_write && !m_wait));              // R9
endmodule

// File: tb/tb_wadp_width_bridge.sv
`timescale 1ns/1ps
module tb_slave_model #(
   parameter int SW = 8,
   parameter int AW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   addr,
   input  logic            rd,
   input  logic            wr,
   input  logic [SW/8-1:0] be_n,
   input  logic [SW-1:0]   wdata,
   output logic [SW-1:0]   rdata,
   output logic            wait_o,
   output int              acc
);
   localparam int SB  = SW / 8;
   localparam int NBY = (1 << AW) * SB;
   logic [7:0] mem [NBY];
   int cnt;

   always_comb begin
      for (int j = 0; j < SB; j++) rdata[j*8 +: 8] = mem[int'(addr)*SB + j];
   end
   assign wait_o = (rd | wr) && (cnt != acc % 3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= 0;
         acc <= 0;
         for (int i = 0; i < NBY; i++) mem[i] <= 8'h00;
      end else if (rd | wr) begin
         if (cnt == acc % 3) begin
            cnt <= 0;
            acc <= acc + 1;
            if (wr) begin
               for (int j = 0; j < SB; j++)
                  if (!be_n[j]) mem[int'(addr)*SB + j] <= wdata[j*8 +: 8];
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end
endmodule

module tb_wadp_width_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic [3:0]  be = 4'hF;
   logic [31:0] wd = '0;
   logic [3:0]  go_rd = '0;
   logic [3:0]  go_wr = '0;
   logic [31:0] rdat [4];
   logic [31:0] last_got [4];
   logic [3:0]  mwt;
   logic [3:0]  srd;
   logic [3:0]  swr;
   int          accs [4];
   logic [7:0]  be64;
   logic [7:0]  shadow [64];
   int          n_run = 0;
   int          n_fail = 0;
   bit          finished = 0;

   always #2 clk = ~clk;

   for (genvar k = 0; k < 4; k++) begin : g_cfg
      localparam int SW  = 8 << k;
      localparam int SB  = SW / 8;
      localparam int SAW = 6 - $clog2(SB);
      logic [SAW-1:0] sa;
      logic [SB-1:0]  sbe;
      logic [SW-1:0]  swd;
      logic [SW-1:0]  srdd;
      logic           sr_, sw_, sws, w;
      logic [31:0]    r;
      int             acc_i;

      wadp_width_bridge #(.SLV_W(SW), .M_ADDR_W(6)) dut (
         .clk(clk), .rst_n(rst_n), .m_addr(addr), .m_read(go_rd[k]),
         .m_write(go_wr[k]), .m_be_n(be), .m_wdata(wd), .m_rdata(r),
         .m_wait(w), .s_addr(sa), .s_read(sr_), .s_write(sw_),
         .s_be_n(sbe), .s_wdata(swd), .s_rdata(srdd), .s_wait(sws)
      );
      tb_slave_model #(.SW(SW), .AW(SAW)) u_slv (
         .clk(clk), .rst_n(rst_n), .addr(sa), .rd(sr_), .wr(sw_),
         .be_n(sbe), .wdata(swd), .rdata(srdd), .wait_o(sws), .acc(acc_i)
      );
      assign rdat[k] = r;
      assign mwt[k]  = w;
      assign srd[k]  = sr_;
      assign swr[k]  = sw_;
      assign accs[k] = acc_i;
      if (k == 3) begin : g_w64
         assign be64 = sbe;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   function automatic int exp_n(input int k, input logic [3:0] b);
      int sb = 1 << k;
      int n = 0;
      if (sb >= 4) return (b != 4'hF) ? 1 : 0;
      for (int g = 0; g < 4 / sb; g++) begin
         bit any = 0;
         for (int j = 0; j < sb; j++) if (!b[g*sb + j]) any = 1;
         if (any) n++;
      end
      return n;
   endfunction

   function automatic int exp_cyc(input int a0, input int n);
      int s = 0;
      if (n == 0) return 1;
      for (int i = 0; i < n; i++) s += (a0 + i) % 3 + 1;
      return s;
   endfunction

   function automatic logic [3:0] pat(input int i);
      case (i)
         0: return 4'b0000;
         1: return 4'b1100;
         2: return 4'b0011;
         3: return 4'b1110;
         4: return 4'b1101;
         5: return 4'b1011;
         6: return 4'b0111;
         default: return 4'b1111;
      endcase
   endfunction

   // entered and left on a falling edge
   task automatic xfer(input bit wr_op, input logic [5:0] a, input logic [3:0] b,
                       input logic [31:0] d);
      logic [3:0] act_m = 4'hF;
      logic [3:0] drop = '0;
      int cyc [4];
      int a0 [4];
      bit halfbad = 0;
      bit saw64 = 0;
      logic [7:0] exp64;
      exp64 = a[2] ? {b, 4'hF} : {4'hF, b};
      addr = a; be = b; wd = d;
      for (int k = 0; k < 4; k++) begin a0[k] = accs[k]; cyc[k] = 0; end
      if (wr_op) go_wr = act_m; else go_rd = act_m;
      while (act_m != 0) begin
         #1;
         if (swr[3]) begin
            saw64 = 1;
            if (be64 != exp64) halfbad = 1;
         end
         for (int k = 0; k < 4; k++) begin
            if (act_m[k]) begin
               cyc[k]++;
               if (!mwt[k]) begin last_got[k] = rdat[k]; drop[k] = 1'b1; end
            end
         end
         @(negedge clk);
         act_m = act_m & ~drop;
         drop = '0;
         if (wr_op) go_wr = act_m; else go_rd = act_m;
      end
      for (int k = 0; k < 4; k++) begin
         int n = exp_n(k, b);
         if (b == 4'hF)  chk(accs[k] - a0[k] == 0, "R3 no slave access", accs[k] - a0[k], 0);
         else if (k == 2) chk(accs[k] - a0[k] == 1, "R8 single access", accs[k] - a0[k], 1);
         else             chk(accs[k] - a0[k] == n, "R2 access count", accs[k] - a0[k], n);
         chk(cyc[k] == exp_cyc(a0[k], n), "R4 master wait length", cyc[k], exp_cyc(a0[k], n));
         if (!wr_op) begin
            for (int j = 0; j < 4; j++)
               if (!b[j]) chk(last_got[k][j*8 +: 8] == shadow[int'(a) + j], "R5 read lane",
                              last_got[k][j*8 +: 8], shadow[int'(a) + j]);
         end
      end
      if (wr_op) begin
         for (int j = 0; j < 4; j++) if (!b[j]) shadow[int'(a) + j] = d[j*8 +: 8];
         if (b != 4'hF) chk(saw64 && !halfbad, "R7 64-bit half lanes", int'(be64), int'(exp64));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seq = 1;
      for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(mwt == 4'h0, "R9 idle wait after reset", int'(mwt), 0);
      chk((srd | swr) == 4'h0, "R9 idle slave strobes", int'(srd | swr), 0);
      @(negedge clk);
      for (int w = 0; w < 16; w++) begin
         for (int bi = 0; bi < 8; bi++) begin
            logic [5:0]  a = 6'(w * 4);
            logic [3:0]  b = pat(bi);
            logic [31:0] d = {8'(seq * 4 + 3), 8'(seq * 4 + 2), 8'(seq * 4 + 1), 8'(seq * 4)};
            seq++;
            xfer(1'b1, a, b, d);
            xfer(1'b0, a, 4'h0, '0);
            for (int k = 0; k < 4; k++)
               for (int j = 0; j < 4; j++) begin
                  if (b[j]) chk(last_got[k][j*8 +: 8] == shadow[int'(a) + j],
                                "R6 disabled byte kept", last_got[k][j*8 +: 8], shadow[int'(a) + j]);
                  else      chk(last_got[k][j*8 +: 8] == d[j*8 +: 8],
                                "R1 byte placement", last_got[k][j*8 +: 8], d[j*8 +: 8]);
               end
            xfer(1'b0, a, b, '0);
         end
      end
      #1;
      chk((srd | swr) == 4'h0, "R9 idle after sweep", int'(srd | swr), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule